// File: doc/BRIEF.md
# Quick-Command Wiper Engine

This block holds a small bank of 8-bit wiper positions, each paired with a shadow register that stands in for non-volatile storage. A host issues a 4-bit quick command together with a channel number and a one-cycle strobe. The command can step a wiper by one position or by a factor of two (6 dB), either on one channel or on all channels at once. It can also copy a wiper into its shadow register, copy a shadow register back into its wiper, reload every wiper from its shadow register, or do nothing.

A store or a full reload starts a timed busy window that models the non-volatile write cycle. While the window is open the block drops every command and reports a would-be NACK. A poll strobe returns an acknowledge only after the window has closed. An active-low write-protect input blocks every change to wipers and shadow registers, and read-back of both kinds of register keeps working while it is low.

A restore command puts the block into an active read state. A NOP command returns it to idle. An optional trailing data byte may follow a command; the block takes it and discards it.

Top module: `qcmd_pot_engine`

## Requirements
- R1: After synchronous reset every wiper and every shadow register holds SHADOW_INIT (0x80 by default), and `busy`, `busy_nack`, `poll_ack` and `active` are 0.
- R2: Code 10 adds one to the addressed wiper and holds it at 255. Code 5 subtracts one from the addressed wiper and holds it at 0.
- R3: Code 11 and code 6 apply the same one-step increment and decrement, each with the same saturation, to every wiper in the same cycle.
- R4: Code 8 doubles the addressed wiper and code 9 doubles every wiper. A value with bit 7 set becomes 255, and 0 becomes 1. Code 3 halves the addressed wiper and code 4 halves every wiper (logical shift right by one).
- R5: Code 2 copies the addressed wiper into its shadow register. `busy` rises on the cycle after the command and stays high for exactly BUSY_CYCLES cycles, and the shadow register holds the new value once `busy` has fallen.
- R6: Code 1 loads the addressed wiper from its shadow register and sets `active` to 1. Code 0 changes no register and clears `active` to 0.
- R7: Code 7 loads every wiper from its own shadow register and starts the same busy window as R5.
- R8: While `busy` is high, a command, poll or data strobe is dropped and `busy_nack` is 1 on the next cycle. A poll gives `poll_ack` = 1 on the next cycle only when `busy` is low.
- R9: While `wp_n` is 0, codes 1 to 11 change no wiper and no shadow register, start no busy window and leave `active` unchanged. `wiper_rd` and `shadow_rd` still return the stored values.
- R10: Codes 12 to 15 change no wiper, no shadow register, and neither `busy` nor `active`.
- R11: A `data_valid` strobe with any `data_byte`, whether on its own or on the cycle after a command, changes no wiper and no shadow register.
- R12: `wiper_rd` and `shadow_rd` show the registers of channel `rd_chan` one clock after `rd_chan` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 4 | Quick-command code |
| cmd_chan | input | CH_W (2) | Addressed channel |
| data_valid | input | 1 | Trailing data byte strobe |
| data_byte | input | 8 | Trailing data byte (discarded) |
| wp_n | input | 1 | Write protect, active low |
| poll | input | 1 | Acknowledge-poll strobe |
| rd_chan | input | CH_W (2) | Channel selected for read-back |
| wiper_rd | output | WIPER_W (8) | Registered wiper of `rd_chan` |
| shadow_rd | output | WIPER_W (8) | Registered shadow register of `rd_chan` |
| busy | output | 1 | Non-volatile write window open |
| busy_nack | output | 1 | A strobe arrived while busy |
| poll_ack | output | 1 | Poll acknowledged |
| active | output | 1 | Read power state after a restore |

## Verification
The hardest situation to reach is a command that lands inside an open busy window. The block must drop it and still commit the pending shadow write at the end of the window. The bench opens the window with a store and sends a poll and then a decrement on the following cycles, while the counter is still running. It then waits for `busy` to fall and reads back both registers of that channel. Saturation at both ends and the 0-to-1 doubling case need long chains of steps. The bench halves one wiper down to 0 and drives another wiper into its top value before testing each end.

// File: rtl/qcp_pkg.sv
package qcp_pkg;

  typedef enum logic [3:0] {
    CMD_NOP        = 4'd0,
    CMD_RESTORE    = 4'd1,
    CMD_STORE      = 4'd2,
    CMD_HALF_ONE   = 4'd3,
    CMD_HALF_ALL   = 4'd4,
    CMD_DEC_ONE    = 4'd5,
    CMD_DEC_ALL    = 4'd6,
    CMD_RELOAD_ALL = 4'd7,
    CMD_DBL_ONE    = 4'd8,
    CMD_DBL_ALL    = 4'd9,
    CMD_INC_ONE    = 4'd10,
    CMD_INC_ALL    = 4'd11
  } qcmd_e;

  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_HALF = 3'd1,
    OP_DEC  = 3'd2,
    OP_DBL  = 3'd3,
    OP_INC  = 3'd4,
    OP_LOAD = 3'd5
  } wop_e;

  typedef struct packed {
    wop_e op;       // wiper operation
    logic all_ch;   // apply to every channel
    logic store;    // wiper -> shadow
    logic reload;   // all shadows -> all wipers, timed
    logic restore;  // one shadow -> wiper, enters read state
    logic nop;      // returns to idle
  } qcp_dec_t;

endpackage

// File: rtl/qcp_decode.sv
module qcp_decode
  import qcp_pkg::*;
(
  input  logic [3:0] cmd_code,
  output qcp_dec_t   dec
);

  always_comb begin
    dec = '{op: OP_HOLD, all_ch: 1'b0, store: 1'b0, reload: 1'b0,
            restore: 1'b0, nop: 1'b0};
    case (cmd_code)
      CMD_NOP:        dec.nop = 1'b1;
      CMD_RESTORE:    begin dec.op = OP_LOAD; dec.restore = 1'b1; end
      CMD_STORE:      dec.store = 1'b1;
      CMD_HALF_ONE:   dec.op = OP_HALF;
      CMD_HALF_ALL:   begin dec.op = OP_HALF; dec.all_ch = 1'b1; end
      CMD_DEC_ONE:    dec.op = OP_DEC;
      CMD_DEC_ALL:    begin dec.op = OP_DEC; dec.all_ch = 1'b1; end
      CMD_RELOAD_ALL: begin dec.op = OP_LOAD; dec.all_ch = 1'b1; dec.reload = 1'b1; end
      CMD_DBL_ONE:    dec.op = OP_DBL;
      CMD_DBL_ALL:    begin dec.op = OP_DBL; dec.all_ch = 1'b1; end
      CMD_INC_ONE:    dec.op = OP_INC;
      CMD_INC_ALL:    begin dec.op = OP_INC; dec.all_ch = 1'b1; end
      default:        ; // reserved codes: no operation at all
    endcase
  end

endmodule

// File: rtl/qcp_step.sv
module qcp_step
  import qcp_pkg::*;
#(
  parameter int unsigned WIPER_W = 8
) (
  input  logic [WIPER_W-1:0] cur,
  input  logic [WIPER_W-1:0] load_val,
  input  wop_e               op,
  output logic [WIPER_W-1:0] nxt
);

  localparam logic [WIPER_W-1:0] TOP  = {WIPER_W{1'b1}};
  localparam logic [WIPER_W-1:0] ZERO = '0;
  localparam logic [WIPER_W-1:0] ONE  = WIPER_W'(1);

  always_comb begin
    case (op)
      OP_HALF: nxt = cur >> 1;
      OP_DEC:  nxt = (cur == ZERO) ? ZERO : cur - ONE;
      OP_DBL: begin
        if (cur == ZERO)          nxt = ONE;
        else if (cur[WIPER_W-1])  nxt = TOP;
        else                      nxt = cur << 1;
      end
      OP_INC:  nxt = (cur == TOP) ? TOP : cur + ONE;
      OP_LOAD: nxt = load_val;
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/qcp_busy_timer.sv
module qcp_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);

  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (start)    cnt <= CW'(BUSY_CYCLES);
    else if (cnt != 0) cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
  assign last = (cnt == CW'(1));

endmodule

// File: rtl/qcmd_pot_engine.sv
module qcmd_pot_engine
  import qcp_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned WIPER_W     = 8,
  parameter int unsigned BUSY_CYCLES = 8,
  parameter int unsigned SHADOW_INIT = 128,
  localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [3:0]         cmd_code,
  input  logic [CH_W-1:0]    cmd_chan,
  input  logic               data_valid,
  input  logic [7:0]         data_byte,
  input  logic               wp_n,
  input  logic               poll,
  input  logic [CH_W-1:0]    rd_chan,
  output logic [WIPER_W-1:0] wiper_rd,
  output logic [WIPER_W-1:0] shadow_rd,
  output logic               busy,
  output logic               busy_nack,
  output logic               poll_ack,
  output logic               active
);

  localparam logic [WIPER_W-1:0] INIT_VAL = WIPER_W'(SHADOW_INIT);

  qcp_dec_t dec;
  logic accept, wr_ok, start_nv, nv_last;

  logic [WIPER_W-1:0] wiper  [NUM_CH];
  logic [WIPER_W-1:0] shadow [NUM_CH];
  logic [WIPER_W-1:0] pend_val;
  logic [CH_W-1:0]    pend_ch;
  logic               pend_store;
  logic [NUM_CH*WIPER_W-1:0] wiper_flat;

  // The trailing byte is taken and thrown away.
  logic unused_data;
  assign unused_data = ^data_byte;

  qcp_decode u_dec (
    .cmd_code (cmd_code),
    .dec      (dec)
  );

  assign accept   = cmd_valid && !busy;
  assign wr_ok    = accept && wp_n;
  assign start_nv = wr_ok && (dec.store || dec.reload);

  qcp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start_nv),
    .busy  (busy),
    .last  (nv_last)
  );

  // Per-channel wiper datapath.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic               sel;
    wop_e               op_i;
    logic [WIPER_W-1:0] nxt;

    assign sel  = dec.all_ch || (cmd_chan == CH_W'(i));
    assign op_i = (wr_ok && sel) ? dec.op : OP_HOLD;

    qcp_step #(.WIPER_W(WIPER_W)) u_step (
      .cur      (wiper[i]),
      .load_val (shadow[i]),
      .op       (op_i),
      .nxt      (nxt)
    );

    always_ff @(posedge clk) begin
      if (rst) wiper[i] <= INIT_VAL;
      else     wiper[i] <= nxt;
    end

    assign wiper_flat[i*WIPER_W +: WIPER_W] = wiper[i];
  end

  // Pending shadow write, committed on the last busy cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_store <= 1'b0;
      pend_ch    <= '0;
      pend_val   <= '0;
    end else if (start_nv) begin
      pend_store <= dec.store;
      pend_ch    <= cmd_chan;
      pend_val   <= wiper[cmd_chan];
    end else if (nv_last) begin
      pend_store <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_CH; k++) shadow[k] <= INIT_VAL;
    end else if (nv_last && pend_store) begin
      shadow[pend_ch] <= pend_val;
    end
  end

  // Status and read-back, all registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_nack <= 1'b0;
      poll_ack  <= 1'b0;
      active    <= 1'b0;
      wiper_rd  <= '0;
      shadow_rd <= '0;
    end else begin
      busy_nack <= busy && (cmd_valid || poll || data_valid);
      poll_ack  <= poll && !busy;
      if (wr_ok && dec.restore)   active <= 1'b1;
      else if (accept && dec.nop) active <= 1'b0;
      wiper_rd  <= wiper[rd_chan];
      shadow_rd <= shadow[rd_chan];
    end
  end

endmodule

// File: rtl/qcp_checker.sv
module qcp_checker #(
  parameter int unsigned FLAT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [3:0]        cmd_code,
  input logic              wp_n,
  input logic              poll,
  input logic              busy,
  input logic              busy_nack,
  input logic              poll_ack,
  input logic              active,
  input logic [FLAT_W-1:0] wiper_flat
);

  // R8: commands during busy are dropped and flagged
  a_r8_drop_when_busy: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && busy) |=> ($stable(wiper_flat) && busy_nack));

  // R8: poll acknowledged only when idle
  a_r8_poll_ack_idle: assert property (@(posedge clk) disable iff (rst)
    (poll && !busy) |=> poll_ack);

  a_r8_poll_nack_busy: assert property (@(posedge clk) disable iff (rst)
    (poll && busy) |=> !poll_ack);

  // R9: write protect freezes wipers
  a_r9_wp_freezes: assert property (@(posedge clk) disable iff (rst)
    (!wp_n && !busy) |=> $stable(wiper_flat));

  // R10: reserved codes do nothing
  a_r10_reserved_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_code >= 4'd12) |=> ($stable(wiper_flat) && !busy));

  // R5 / R7: busy window only opens after an accepted store or reload
  a_r5_busy_source: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid && wp_n && (cmd_code == 4'd2 || cmd_code == 4'd7)));

  // R6: read state entered only by restore
  a_r6_active_source: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(cmd_valid && wp_n && cmd_code == 4'd1));

endmodule

bind qcmd_pot_engine qcp_checker #(.FLAT_W(NUM_CH*WIPER_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .wp_n       (wp_n),
  .poll       (poll),
  .busy       (busy),
  .busy_nack  (busy_nack),
  .poll_ack   (poll_ack),
  .active     (active),
  .wiper_flat (wiper_flat)
);

// File: tb/qcmd_pot_engine_tb.sv
module qcmd_pot_engine_tb;

  localparam int unsigned NB = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_code = '0;
  logic [1:0] cmd_chan = '0;
  logic data_valid = 1'b0;
  logic [7:0] data_byte = '0;
  logic wp_n = 1'b1;
  logic poll = 1'b0;
  logic [1:0] rd_chan = '0;
  logic [7:0] wiper_rd, shadow_rd;
  logic busy, busy_nack, poll_ack, active;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  qcmd_pot_engine #(.NUM_CH(4), .WIPER_W(8), .BUSY_CYCLES(NB), .SHADOW_INIT(128)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_chan(cmd_chan), .data_valid(data_valid), .data_byte(data_byte),
    .wp_n(wp_n), .poll(poll), .rd_chan(rd_chan), .wiper_rd(wiper_rd),
    .shadow_rd(shadow_rd), .busy(busy), .busy_nack(busy_nack),
    .poll_ack(poll_ack), .active(active)
  );

  // {code, channel, read channel, expected wiper}
  localparam int NV = 13;
  localparam logic [15:0] VEC [NV] = '{
    {4'd10, 2'd0, 2'd0, 8'h81},  // R2 inc one
    {4'd5,  2'd0, 2'd0, 8'h80},  // R2 dec one
    {4'd5,  2'd1, 2'd1, 8'h7F},  // R2 dec other channel
    {4'd8,  2'd2, 2'd2, 8'hFF},  // R4 double with top bit set -> 255
    {4'd10, 2'd2, 2'd2, 8'hFF},  // R2 inc saturates at 255
    {4'd3,  2'd3, 2'd3, 8'h40},  // R4 halve one
    {4'd4,  2'd0, 2'd3, 8'h20},  // R4 halve all
    {4'd9,  2'd0, 2'd1, 8'h7E},  // R4 double all
    {4'd11, 2'd0, 2'd2, 8'hFF},  // R3 inc all
    {4'd6,  2'd0, 2'd0, 8'h80},  // R3 dec all
    {4'd12, 2'd0, 2'd0, 8'h80},  // R10 reserved
    {4'd15, 2'd1, 2'd1, 8'h7E},  // R10 reserved
    {4'd0,  2'd0, 2'd3, 8'h40}   // R6 nop leaves wipers
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [1:0] ch);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c; cmd_chan = ch;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ch);
    @(negedge clk);
    rd_chan = ch;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int ch = 0; ch < 4; ch++) begin
      rd(2'(ch));
      chk("R1 wiper", wiper_rd, 8'h80);
      chk("R1 shadow", shadow_rd, 8'h80);
    end
    chk("R1 busy", busy, 0);
    chk("R1 active", active, 0);
    chk("R1 nack", busy_nack, 0);

    // Table walk (R2, R3, R4, R10, R12)
    for (int v = 0; v < NV; v++) begin
      issue(VEC[v][15:12], VEC[v][11:10]);
      rd(VEC[v][9:8]);
      chk($sformatf("vector %0d (R12 read)", v), wiper_rd, VEC[v][7:0]);
    end
    // state: ch0 80, ch1 7E, ch2 FE, ch3 40
    rd(2'd2); chk("R3 ch2 after dec all", wiper_rd, 8'hFE);
    rd(2'd1); chk("R10 shadow untouched", shadow_rd, 8'h80);

    // R4 / R2 lower corners
    for (int k = 0; k < 7; k++) issue(4'd3, 2'd3);
    rd(2'd3); chk("R4 halve to zero", wiper_rd, 8'h00);
    issue(4'd5, 2'd3);
    rd(2'd3); chk("R2 dec saturates at 0", wiper_rd, 8'h00);
    issue(4'd8, 2'd3);
    rd(2'd3); chk("R4 double of zero is one", wiper_rd, 8'h01);
    issue(4'd10, 2'd2);  // ch2 -> FF

    // R5 store and busy length
    issue(4'd2, 2'd1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R5 busy length", n, NB);
    rd(2'd1); chk("R5 shadow stored", shadow_rd, 8'h7E);

    // R8 activity inside busy window
    issue(4'd2, 2'd2);
    chk("R5 busy after store", busy, 1);
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
    chk("R8 poll nack", busy_nack, 1);
    chk("R8 no ack while busy", poll_ack, 0);
    cmd_valid = 1'b1; cmd_code = 4'd5; cmd_chan = 2'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 cmd nack", busy_nack, 1);
    wait_idle();
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
    chk("R8 ack after busy", poll_ack, 1);
    chk("R8 no nack after busy", busy_nack, 0);
    rd(2'd2);
    chk("R8 dropped dec", wiper_rd, 8'hFF);
    chk("R5 shadow ch2", shadow_rd, 8'hFF);

    // R6 restore and nop
    issue(4'd10, 2'd1);
    rd(2'd1); chk("R2 inc ch1", wiper_rd, 8'h7F);
    issue(4'd1, 2'd1);
    rd(2'd1); chk("R6 restored", wiper_rd, 8'h7E);
    chk("R6 active set", active, 1);
    issue(4'd0, 2'd0);
    chk("R6 nop clears active", active, 0);

    // R7 reload all
    issue(4'd7, 2'd0);
    chk("R7 busy", busy, 1);
    wait_idle();
    rd(2'd3); chk("R7 ch3 reloaded", wiper_rd, 8'h80);
    rd(2'd2); chk("R7 ch2 reloaded", wiper_rd, 8'hFF);

    // R9 write protect
    wp_n = 1'b0;
    issue(4'd10, 2'd3);
    rd(2'd3); chk("R9 wiper frozen", wiper_rd, 8'h80);
    chk("R9 shadow readable", shadow_rd, 8'h80);
    issue(4'd2, 2'd0);
    chk("R9 no busy", busy, 0);
    issue(4'd1, 2'd3);
    chk("R9 active unchanged", active, 0);
    issue(4'd9, 2'd0);
    rd(2'd2); chk("R9 all-double blocked", wiper_rd, 8'hFF);
    wp_n = 1'b1;

    // R11 trailing data byte ignored
    @(negedge clk);
    data_valid = 1'b1; data_byte = 8'hFF;
    @(negedge clk);
    data_valid = 1'b0;
    rd(2'd0);
    chk("R11 lone byte wiper", wiper_rd, 8'h80);
    chk("R11 lone byte shadow", shadow_rd, 8'h80);
    issue(4'd10, 2'd0);
    data_valid = 1'b1; data_byte = 8'h00;
    @(negedge clk);
    data_valid = 1'b0;
    rd(2'd0);
    chk("R11 byte after cmd", wiper_rd, 8'h81);
    chk("R11 shadow after byte", shadow_rd, 8'h80);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule